// File: doc/BRIEF.md
# USB Transceiver Control Register Bank

This block is the register file a USB transceiver exposes to its link controller, reached through a plain parallel access port. It takes an 8-bit address, 8-bit write data, and separate write and read strobes. Read data is combinational and valid in the same cycle as the read strobe. The main control registers each sit behind a group of three addresses: plain load, bit set, and bit clear. A read at any address of the group returns the stored value. The bank also holds four identification bytes, a live view of five sensed line conditions, and an extended-access indicator byte.

Each condition bit has a rising-edge enable and a falling-edge enable. These drive a sticky interrupt latch that empties itself when read. The function, interface and OTG control bytes leave the block as outputs so they can drive the transceiver. The function-control reset bit clears itself after one cycle. It also starts a pulse of programmable length on a reset-active output. Register contents survive that pulse.

Top module: `phyRegBank`

## Requirements
- R1: After reset, function control reads 0x41 (full speed, suspend deasserted). Interface control, OTG control, the enables, scratch and the indicator byte read 0x00, and resetActive is 0.
- R2: A write to the first address of a group loads the data. A read at any of its three addresses returns the stored value. The groups start at 0x04 (function), 0x07 (interface), 0x0A (OTG), 0x0D (rising enable), 0x10 (falling enable) and 0x16 (scratch). The function, interface and OTG values also appear on their output ports.
- R3: A write to group start + 1 ORs the data into the register.
- R4: A write to group start + 2 clears every register bit that is 1 in the data.
- R5: Addresses 0x00, 0x01, 0x02 and 0x03 return the vendor identifier low byte, the vendor identifier high byte, the product identifier low byte and the product identifier high byte. Writes to them have no effect.
- R6: Address 0x13 returns the live condition inputs in bits 4:0, with bits 7:5 zero. The bit assignment is: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end, bit 4 ID grounded.
- R7: Latch bit n sets when condition n goes from 0 to 1 while bit n of the rising enable is 1. It also sets when condition n goes from 1 to 0 while bit n of the falling enable is 1. No other change sets it.
- R8: A read of 0x14 returns the latch in bits 4:0 and clears the latch at the end of that cycle.
- R9: If a latch set event happens in the same cycle as a read of 0x14, the bit is set afterwards and the event is not lost.
- R10: Bit 5 of function control returns to 0 one cycle after being set, and the other bits keep their value. On that clock edge resetActive goes high, and it stays high for exactly RESET_CYCLES cycles.
- R11: Address 0x2F is a plain read-write byte.
- R12: Addresses 0x15, 0x19 to 0x2E and 0x30 to 0xFF read 0x00. Writes to them, and writes to 0x13 and 0x14, change no register.
- R13: rdData is 0x00 whenever rdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| condIn | input | 5 | Live sensed line conditions |
| rdData | output | 8 | Read data, same cycle as rdEn |
| funcCtrl | output | 8 | Function control contents |
| ifaceCtrl | output | 8 | Interface control contents |
| otgCtrl | output | 8 | OTG control contents |
| resetActive | output | 1 | Transceiver reset pulse |

## Verification
The bench builds the bank with RESET_CYCLES set to 3, so the whole reset pulse and its end can be counted cycle by cycle in a few clocks. It uses identifier values whose four bytes all differ, so a swapped byte order in the identification reads shows up as a wrong value. With these settings, the latch sequences drive rising and falling condition edges against chosen enable bits. One of them lines an edge event up with the clearing read in the same cycle.

// File: rtl/phy_reg_pkg.sv
package phy_reg_pkg;
  localparam int REG_W      = 8;
  localparam int COND_W     = 5;
  localparam int TRIP_COUNT = 6;

  // group start addresses; index order is fixed and used by the datapath
  localparam logic [7:0] TRIP_BASE [TRIP_COUNT] =
    '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h10, 8'h16};
  localparam int IDX_FUNC    = 0;
  localparam int IDX_IFACE   = 1;
  localparam int IDX_OTG     = 2;
  localparam int IDX_RISE    = 3;
  localparam int IDX_FALL    = 4;
  localparam int IDX_SCRATCH = 5;

  localparam logic [7:0] ADDR_ID_LAST = 8'h03;
  localparam logic [7:0] ADDR_STATUS  = 8'h13;
  localparam logic [7:0] ADDR_LATCH   = 8'h14;
  localparam logic [7:0] ADDR_EXT     = 8'h2F;

  localparam logic [REG_W-1:0] FUNC_POR = 8'h41;
  localparam int FUNC_RST_BIT = 5;

  typedef enum logic [2:0] {
    RD_NONE, RD_ID, RD_TRIP, RD_STATUS, RD_LATCH, RD_EXT
  } rdKind_e;

  typedef struct packed {
    logic [TRIP_COUNT-1:0] load;
    logic [TRIP_COUNT-1:0] setBits;
    logic [TRIP_COUNT-1:0] clrBits;
    logic                  extWr;
    logic                  latchRd;
    rdKind_e               rdKind;
    logic [2:0]            rdIdx;
  } bankStrobes_t;
endpackage

// File: rtl/phyRegDecode.sv
module phyRegDecode
  import phy_reg_pkg::*;
(
  input  logic [7:0]   addr,
  input  logic         wrEn,
  input  logic         rdEn,
  output bankStrobes_t strb
);
  logic [7:0] offset;

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    offset      = '0;
    for (int i = 0; i < TRIP_COUNT; i++) begin
      offset = addr - TRIP_BASE[i];
      if (offset < 8'd3) begin
        strb.rdKind     = RD_TRIP;
        strb.rdIdx      = 3'(i);
        strb.load[i]    = wrEn && (offset == 8'd0);
        strb.setBits[i] = wrEn && (offset == 8'd1);
        strb.clrBits[i] = wrEn && (offset == 8'd2);
      end
    end
    if (addr <= ADDR_ID_LAST) begin
      strb.rdKind = RD_ID;
      strb.rdIdx  = {1'b0, addr[1:0]};
    end
    if (addr == ADDR_STATUS) strb.rdKind = RD_STATUS;
    if (addr == ADDR_LATCH) begin
      strb.rdKind  = RD_LATCH;
      strb.latchRd = rdEn;
    end
    if (addr == ADDR_EXT) begin
      strb.rdKind = RD_EXT;
      strb.extWr  = wrEn;
    end
    if (!rdEn) strb.rdKind = RD_NONE;
  end
endmodule

// File: rtl/phyRegCore.sv
module phyRegCore
  import phy_reg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h5A17,
  parameter logic [15:0] PRODUCT_ID   = 16'h0C3E,
  parameter int          RESET_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  wrData,
  input  logic [COND_W-1:0] condIn,
  input  bankStrobes_t      strb,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  funcCtrl,
  output logic [REG_W-1:0]  ifaceCtrl,
  output logic [REG_W-1:0]  otgCtrl,
  output logic              resetActive
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [31:0] ID_WORD = {PRODUCT_ID, VENDOR_ID};

  logic [TRIP_COUNT-1:0][REG_W-1:0] trip;
  logic [REG_W-1:0]  extQ;
  logic [COND_W-1:0] prevCond, latchQ, setEv;
  logic [CNT_W-1:0]  rstCnt;

  for (genvar g = 0; g < TRIP_COUNT; g++) begin : gTrip
    localparam logic [REG_W-1:0] POR = (g == IDX_FUNC) ? FUNC_POR : '0;
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)                q <= POR;
      else if (strb.load[g])    q <= wrData;
      else if (strb.setBits[g]) q <= q | wrData;
      else if (strb.clrBits[g]) q <= q & ~wrData;
      else if (g == IDX_FUNC)   q[FUNC_RST_BIT] <= 1'b0;
    end
    assign trip[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            extQ <= '0;
    else if (strb.extWr)  extQ <= wrData;
  end

  // edge-qualified interrupt latch; a new event outranks the clearing read
  assign setEv = (condIn & ~prevCond & trip[IDX_RISE][COND_W-1:0])
               | (~condIn & prevCond & trip[IDX_FALL][COND_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCond <= '0;
      latchQ   <= '0;
    end else begin
      prevCond <= condIn;
      latchQ   <= (strb.latchRd ? '0 : latchQ) | setEv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           rstCnt <= '0;
    else if (trip[IDX_FUNC][FUNC_RST_BIT]) rstCnt <= CNT_W'(RESET_CYCLES);
    else if (rstCnt != '0)               rstCnt <= rstCnt - 1'b1;
  end
  assign resetActive = (rstCnt != '0);

  always_comb begin
    rdData = '0;
    unique case (strb.rdKind)
      RD_ID:     rdData = ID_WORD[strb.rdIdx[1:0]*8 +: 8];
      RD_TRIP: begin
        for (int i = 0; i < TRIP_COUNT; i++)
          if (strb.rdIdx == 3'(i)) rdData = trip[i];
      end
      RD_STATUS: rdData = {{(REG_W-COND_W){1'b0}}, condIn};
      RD_LATCH:  rdData = {{(REG_W-COND_W){1'b0}}, latchQ};
      RD_EXT:    rdData = extQ;
      default:   rdData = '0;
    endcase
  end

  assign funcCtrl  = trip[IDX_FUNC];
  assign ifaceCtrl = trip[IDX_IFACE];
  assign otgCtrl   = trip[IDX_OTG];
endmodule

// File: rtl/phyRegBank.sv
module phyRegBank #(
  parameter logic [15:0] VENDOR_ID    = 16'h5A17,
  parameter logic [15:0] PRODUCT_ID   = 16'h0C3E,
  parameter int          RESET_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [4:0] condIn,
  output logic [7:0] rdData,
  output logic [7:0] funcCtrl,
  output logic [7:0] ifaceCtrl,
  output logic [7:0] otgCtrl,
  output logic       resetActive
);
  phy_reg_pkg::bankStrobes_t strb;

  phyRegDecode i_decode (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  phyRegCore #(
    .VENDOR_ID    (VENDOR_ID),
    .PRODUCT_ID   (PRODUCT_ID),
    .RESET_CYCLES (RESET_CYCLES)
  ) i_core (
    .clk         (clk),
    .rstN        (rstN),
    .wrData      (wrData),
    .condIn      (condIn),
    .strb        (strb),
    .rdData      (rdData),
    .funcCtrl    (funcCtrl),
    .ifaceCtrl   (ifaceCtrl),
    .otgCtrl     (otgCtrl),
    .resetActive (resetActive)
  );
endmodule

// File: rtl/phyRegBankChk.sv
module phyRegBankChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addr,
  input logic [7:0] wrData,
  input logic       wrEn,
  input logic       rdEn,
  input logic [4:0] condIn,
  input logic [7:0] rdData,
  input logic [7:0] funcCtrl,
  input logic [7:0] ifaceCtrl,
  input logic [7:0] otgCtrl,
  input logic       resetActive
);
  logic roWrite;
  assign roWrite = wrEn && (addr <= 8'h03 || addr == 8'h13 || addr == 8'h14 ||
                   addr == 8'h15 || (addr >= 8'h19 && addr <= 8'h2E) || addr >= 8'h30);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h07) |=> ifaceCtrl == $past(wrData));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h08) |=> ifaceCtrl == ($past(ifaceCtrl) | $past(wrData)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h09) |=> ifaceCtrl == ($past(ifaceCtrl) & ~$past(wrData)));

  assert_status_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h13) |-> rdData == {3'b000, condIn});

  assert_selfclear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (funcCtrl[5] && !wrEn) |=> !funcCtrl[5]);

  assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    funcCtrl[5] |=> resetActive);

  assert_ro_write_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (roWrite && !funcCtrl[5]) |=> ($stable(funcCtrl) && $stable(ifaceCtrl) && $stable(otgCtrl)));

  assert_idle_read_R13: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 8'h00);
endmodule

bind phyRegBank phyRegBankChk i_chk (.*);

// File: tb/test_phyRegBank.sv
module test_phyRegBank;
  localparam int          CLK_PERIOD = 10;
  localparam int          RST_CYCLES = 3;
  localparam logic [15:0] VID = 16'hB7E2;
  localparam logic [15:0] PID = 16'h3C91;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h04, 8'h00, 8'h41, 4'd1},   // R1 function control POR
    '{1'b0, 1'b1, 8'h0A, 8'h00, 8'h00, 4'd1},   // R1 OTG POR
    '{1'b1, 1'b0, 8'h07, 8'hA5, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h07, 8'h00, 8'hA5, 4'd2},   // R2 load then read
    '{1'b0, 1'b1, 8'h08, 8'h00, 8'hA5, 4'd2},
    '{1'b0, 1'b1, 8'h09, 8'h00, 8'hA5, 4'd2},
    '{1'b1, 1'b0, 8'h08, 8'h0A, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h07, 8'h00, 8'hAF, 4'd3},   // R3 OR in
    '{1'b1, 1'b0, 8'h09, 8'h21, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h08, 8'h00, 8'h8E, 4'd4},   // R4 clear bits
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hE2, 4'd5},   // R5 identification order
    '{1'b0, 1'b1, 8'h01, 8'h00, 8'hB7, 4'd5},
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'h91, 4'd5},
    '{1'b0, 1'b1, 8'h03, 8'h00, 8'h3C, 4'd5},
    '{1'b1, 1'b0, 8'h01, 8'hFF, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h01, 8'h00, 8'hB7, 4'd5},   // R5 write ignored
    '{1'b1, 1'b0, 8'h16, 8'h3C, 8'h00, 4'd0},
    '{1'b1, 1'b0, 8'h17, 8'hC0, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h18, 8'h00, 8'hFC, 4'd3},   // R3 scratch
    '{1'b1, 1'b0, 8'h2F, 8'h5A, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h2F, 8'h00, 8'h5A, 4'd11},  // R11 indicator byte
    '{1'b1, 1'b0, 8'h20, 8'h77, 8'h00, 4'd0},
    '{1'b1, 1'b0, 8'h15, 8'h77, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h20, 8'h00, 8'h00, 4'd12},  // R12 reserved reads zero
    '{1'b0, 1'b1, 8'h15, 8'h00, 8'h00, 4'd12},
    '{1'b0, 1'b1, 8'h30, 8'h00, 8'h00, 4'd12},
    '{1'b1, 1'b0, 8'h13, 8'hFF, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h0A, 8'h00, 8'h00, 4'd12},  // R12 no side effect
    '{1'b1, 1'b0, 8'h0A, 8'h06, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h0C, 8'h00, 8'h06, 4'd2},
    '{1'b1, 1'b0, 8'h04, 8'h15, 8'h00, 4'd0},
    '{1'b0, 1'b1, 8'h06, 8'h00, 8'h15, 4'd2},
    '{1'b1, 1'b0, 8'h04, 8'h41, 8'h00, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0] condIn = '0;
  logic [7:0] rdData, funcCtrl, ifaceCtrl, otgCtrl;
  logic       resetActive;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyRegBank #(.VENDOR_ID(VID), .PRODUCT_ID(PID), .RESET_CYCLES(RST_CYCLES)) i_phyRegBank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .condIn(condIn), .rdData(rdData), .funcCtrl(funcCtrl), .ifaceCtrl(ifaceCtrl),
    .otgCtrl(otgCtrl), .resetActive(resetActive)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; rdEn = 1'b0; addr = a; wrData = d;
    @(posedge clk);
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b1; addr = a;
    #1 check(req, rdData, exp);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 funcCtrl", funcCtrl, 8'h41);
    check("R1 ifaceCtrl", ifaceCtrl, 8'h00);
    check("R1 otgCtrl", otgCtrl, 8'h00);
    check("R1 resetActive", {7'b0, resetActive}, 8'h00);
    addr = 8'h04;
    check("R13 idle read", rdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].wr; rdEn = VECS[i].rd; addr = VECS[i].addr; wrData = VECS[i].data;
      #1;
      if (VECS[i].rd) check($sformatf("R%0d table %0d", VECS[i].req, i), rdData, VECS[i].exp);
      @(posedge clk);
    end
    idle();
    check("R2 ifaceCtrl port", ifaceCtrl, 8'h8E);
    check("R2 otgCtrl port", otgCtrl, 8'h06);

    // R6 live status
    @(negedge clk); condIn = 5'b10101;
    rdCheck(8'h13, 8'h15, "R6 status a");
    @(negedge clk); condIn = 5'b01010;
    rdCheck(8'h13, 8'h0A, "R6 status b");
    @(negedge clk); condIn = 5'b00000;
    idle();
    rdCheck(8'h14, 8'h00, "R7 latch empty");

    // R7 edge enables: rise on bit 1, fall on bit 3
    wrReg(8'h0D, 8'h02);
    wrReg(8'h10, 8'h08);
    @(negedge clk); wrEn = 1'b0; condIn = 5'b00010;
    idle();
    rdCheck(8'h14, 8'h02, "R7 rising enabled");
    rdCheck(8'h14, 8'h00, "R8 cleared by read");
    @(negedge clk); condIn = 5'b00011;
    idle();
    rdCheck(8'h14, 8'h00, "R7 rise not enabled");
    @(negedge clk); condIn = 5'b01011;
    idle();
    rdCheck(8'h14, 8'h00, "R7 rise of fall-only bit");
    @(negedge clk); condIn = 5'b00011;
    idle();
    rdCheck(8'h14, 8'h08, "R7 falling enabled");
    @(negedge clk); condIn = 5'b00001;
    idle();
    rdCheck(8'h14, 8'h00, "R7 fall not enabled");

    // R9 event coincides with clearing read
    @(negedge clk); condIn = 5'b00011; wrEn = 1'b0; rdEn = 1'b1; addr = 8'h14;
    #1 check("R9 pre-edge read", rdData, 8'h00);
    @(posedge clk);
    rdCheck(8'h14, 8'h02, "R9 set wins");

    // R10 self-clearing reset bit and pulse length
    wrReg(8'h05, 8'h20);
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    #1;
    check("R10 bit set", funcCtrl, 8'h61);
    check("R10 pulse not yet", {7'b0, resetActive}, 8'h00);
    begin
      int highCount = 0;
      for (int k = 0; k < RST_CYCLES + 2; k++) begin
        @(negedge clk); #1;
        if (k == 0) check("R10 bit cleared", funcCtrl, 8'h41);
        if (resetActive) highCount++;
      end
      check("R10 pulse length", 8'(highCount), 8'(RST_CYCLES));
    end
    rdCheck(8'h04, 8'h41, "R10 contents kept");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule